// File: doc/BRIEF.md
# Self-Settling Word Queue with Serial and Parallel Ports

This block is a small first-in first-out word buffer. Each word settles toward the output by itself, with no read-side clock request. A word enters through an input holding register. That register takes a whole word from the parallel data pins in one cycle, or it takes one bit per shift strobe from a single serial pin. A transfer request, active low, hands the held word to the first slot of a storage column. On every clock edge, a word in the column moves down one slot if the slot below it is free. The word therefore settles in the lowest free slot, next to the output.

The output holding register takes the word from the bottom slot whenever that register is empty. It can be read in two ways. A read strobe takes the whole word at once, and the parallel pins carry it while the output enable is high. Or the word is shifted out one bit at a time, lowest bit first, with the strobe gated by a serial output enable. Two flags give the handshake on each side: one shows that the input register is full, the other shows that the output register is empty. A synchronous active-low master reset empties the whole path.

Top module: `fallthru_fifo`

## Requirements
- R1: After master reset (`rst_n` low at a clock edge), `in_full` is 0 and `out_empty` is 1.
- R2: When `in_full` is 0 and `par_load` is 1, the word on `din` is captured and `in_full` becomes 1 at that edge. While `in_full` is 1, `par_load` and serial shifts are ignored, so the held word is kept.
- R3: When `ser_in_en` is 1, each `ser_in_shift` strobe shifts `ser_in` into the input register. The first bit shifted ends up in bit 0 of the word. `in_full` becomes 1 on the WIDTH-th shift. A strobe while `ser_in_en` is 0 has no effect.
- R4: When `in_full` is 1, `xfer_n` is 0 and the top slot is free, the held word enters the column and `in_full` clears at the same edge. While `xfer_n` is 1, `in_full` stays 1.
- R5: In an empty queue, `out_empty` falls exactly DEPTH clock edges after the edge that moved the word into the column.
- R6: Words leave in the order in which they were transferred, whatever the entry and exit mode of each word.
- R7: With no reads, the column and the output register together hold DEPTH+1 words. A further word stays in the input register with `in_full` at 1 while `xfer_n` is low. It moves in once a word has been read out.
- R8: A `rd_par` strobe while `out_empty` is 0 sets `out_empty` at that edge. While `oe` is 1, `dout` shows the output word and `dout_oe` is 1. While `oe` is 0, `dout` is all zeros and `dout_oe` is 0.
- R9: When `ser_out_en` is 1, `ser_q` shows bit 0 of the output word, and each `ser_out_shift` moves the next bit into view. `out_empty` becomes 1 after WIDTH shifts. A shift while `ser_out_en` is 0 changes nothing.
- R10: A master reset in the middle of operation discards every stored word. `out_empty` then stays 1 with no new input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| par_load | input | 1 | Capture `din` into the input register |
| din | input | WIDTH | Parallel input word |
| ser_in | input | 1 | Serial input bit |
| ser_in_shift | input | 1 | Serial input shift strobe |
| ser_in_en | input | 1 | Gate for the serial input strobe |
| xfer_n | input | 1 | Active-low request to move the held word into the column |
| in_full | output | 1 | Input register holds a complete word |
| rd_par | input | 1 | Parallel read strobe; releases the output word |
| oe | input | 1 | Enable for the parallel output pins |
| dout | output | WIDTH | Parallel output word, zero while disabled |
| dout_oe | output | 1 | Pad drive enable for `dout` |
| ser_out_shift | input | 1 | Serial output shift strobe |
| ser_out_en | input | 1 | Gate for the serial output strobe |
| ser_q | output | 1 | Serial output bit |
| out_empty | output | 1 | Output register holds no word |

## Verification
The bench builds the block with its default values, a 4-bit word and a 16-slot column. With these values a full fill is short: DEPTH+2 words cover the column, the output register and the input register. That puts the blocked-input case (R7) and the exact settle delay of 16 edges (R5) within reach in a few hundred cycles. A 4-bit word keeps the serial paths to four strobes per word. This makes it cheap to mix serial and parallel entry and exit across a sequence of words and still check their order.

// File: rtl/fff_pkg.sv
// Package: shared types for the self-settling queue.
// Assumes: nothing beyond IEEE 1800-2017.
package fff_pkg;

    // Action taken by the input holding register in one cycle.
    typedef enum logic [1:0] {
        IN_HOLD = 2'd0,
        IN_PAR  = 2'd1,
        IN_SER  = 2'd2,
        IN_XFER = 2'd3
    } in_op_e;

    // Action taken by the output holding register in one cycle.
    typedef enum logic [1:0] {
        OUT_HOLD  = 2'd0,
        OUT_READ  = 2'd1,
        OUT_SHIFT = 2'd2,
        OUT_FILL  = 2'd3
    } out_op_e;

endpackage

// File: rtl/fff_in_reg.sv
// Input holding register: collects one word, either in parallel or
// serially with the lowest bit first, and offers it to the column.
// Assumes: top_free comes from the column's slot 0 in the same cycle.
module fff_in_reg
    import fff_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_load,
    input  logic [WIDTH-1:0] din,
    input  logic             ser_in,
    input  logic             ser_shift,
    input  logic             ser_en,
    input  logic             xfer_n,
    input  logic             top_free,
    output logic [WIDTH-1:0] word,
    output logic             full,
    output logic             push
);
    localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [CW-1:0] bit_cnt;
    in_op_e        op;

    // Hand-off happens when a full word is requested and slot 0 is free.
    assign push = full & ~xfer_n & top_free;

    // Pick this cycle's action; a full register ignores new data.
    always_comb begin
        if (full)                      op = push ? IN_XFER : IN_HOLD;
        else if (par_load)             op = IN_PAR;
        else if (ser_en && ser_shift)  op = IN_SER;
        else                           op = IN_HOLD;
    end

    // Update the word, the shift count and the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word    <= '0;
            full    <= 1'b0;
            bit_cnt <= '0;
        end else begin
            case (op)
                IN_PAR: begin
                    word    <= din;
                    full    <= 1'b1;
                    bit_cnt <= '0;
                end
                IN_SER: begin
                    if (WIDTH > 1) word <= {ser_in, word[WIDTH-1:1]};
                    else           word <= ser_in;
                    if (bit_cnt == LAST) begin
                        full    <= 1'b1;
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                IN_XFER: full <= 1'b0;
                default: ;
            endcase
        end
    end

    assert_load_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && par_load) |=> full);
    assert_full_holds_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !push) |=> (full && $stable(word)));
    assert_xfer_clears_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !full);
    assert_gated_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && !par_load && !ser_en) |=> (!full && $stable(word)));

endmodule

// File: rtl/fff_stack.sv
// Storage column: DEPTH slots, each with a valid bit. A word moves from
// slot i to slot i+1 whenever slot i+1 is empty, one step per clock.
// The bottom slot hands its word to the output register when that
// register is empty. Assumes: push only asserted while top_free is 1.
module fff_stack #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_word,
    input  logic             out_free,
    output logic             top_free,
    output logic             pop,
    output logic [WIDTH-1:0] pop_word
);
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] vld_nxt;
    logic [DEPTH-1:0] leave;
    logic [DEPTH-1:0] arrive;
    logic [WIDTH-1:0] mem [DEPTH];

    // Work out which slots hand on and which receive a word.
    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            if (gi == DEPTH - 1) begin : g_bottom
                assign leave[gi] = vld[gi] & out_free;
            end else begin : g_mid
                assign leave[gi] = vld[gi] & ~vld[gi+1];
            end
            if (gi == 0) begin : g_top
                assign arrive[gi] = push;
            end else begin : g_below
                assign arrive[gi] = leave[gi-1];
            end
        end
    endgenerate

    // Next valid bits after moves and arrivals.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_nxt[i] = (vld[i] & ~leave[i]) | arrive[i];
        end
    end

    // Register the valid bits; reset empties the column.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else        vld <= vld_nxt;
    end

    // Move word contents along with their valid bits.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (arrive[i]) mem[i] <= (i == 0) ? push_word : mem[(i > 0) ? i - 1 : 0];
        end
    end

    assign top_free = ~vld[0];
    assign pop      = leave[DEPTH-1];
    assign pop_word = mem[DEPTH-1];

    assert_words_conserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(vld) == $past($countones(vld)) + int'($past(push)) - int'($past(pop))));
    assert_no_push_into_busy_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !vld[0]);

endmodule

// File: rtl/fff_out_reg.sv
// Output holding register: takes the bottom word when empty and releases
// it by one parallel read or by WIDTH serial shifts, lowest bit first.
// Assumes: load only asserted while empty is 1.
module fff_out_reg
    import fff_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             rd_par,
    input  logic             ser_shift,
    input  logic             ser_en,
    output logic [WIDTH-1:0] word,
    output logic             empty
);
    localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [CW-1:0] bit_cnt;
    out_op_e       op;

    // Pick this cycle's action; a parallel read wins over a shift.
    always_comb begin
        if (!empty && rd_par)                 op = OUT_READ;
        else if (!empty && ser_en && ser_shift) op = OUT_SHIFT;
        else if (empty && load)               op = OUT_FILL;
        else                                  op = OUT_HOLD;
    end

    // Update the word, the shift count and the empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word    <= '0;
            empty   <= 1'b1;
            bit_cnt <= '0;
        end else begin
            case (op)
                OUT_READ: begin
                    empty   <= 1'b1;
                    bit_cnt <= '0;
                end
                OUT_SHIFT: begin
                    word <= word >> 1;
                    if (bit_cnt == LAST) begin
                        empty   <= 1'b1;
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                OUT_FILL: begin
                    word    <= load_word;
                    empty   <= 1'b0;
                    bit_cnt <= '0;
                end
                default: ;
            endcase
        end
    end

    assert_read_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && rd_par) |=> empty);
    assert_fill_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && load) |=> !empty);
    assert_gated_out_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !rd_par && !ser_en) |=> (!empty && $stable(word)));

endmodule

// File: rtl/fallthru_fifo.sv
// Top: input holding register, self-settling storage column and output
// holding register, with full/empty handshake flags on each side.
// Assumes: all controls synchronous to clk; rst_n is the master reset.
module fallthru_fifo #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_load,
    input  logic [WIDTH-1:0] din,
    input  logic             ser_in,
    input  logic             ser_in_shift,
    input  logic             ser_in_en,
    input  logic             xfer_n,
    output logic             in_full,
    input  logic             rd_par,
    input  logic             oe,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    input  logic             ser_out_shift,
    input  logic             ser_out_en,
    output logic             ser_q,
    output logic             out_empty
);
    logic [WIDTH-1:0] in_word;
    logic             push;
    logic             top_free;
    logic             pop;
    logic [WIDTH-1:0] pop_word;
    logic [WIDTH-1:0] out_word;

    fff_in_reg #(.WIDTH(WIDTH)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_load  (par_load),
        .din       (din),
        .ser_in    (ser_in),
        .ser_shift (ser_in_shift),
        .ser_en    (ser_in_en),
        .xfer_n    (xfer_n),
        .top_free  (top_free),
        .word      (in_word),
        .full      (in_full),
        .push      (push)
    );

    fff_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (in_word),
        .out_free  (out_empty),
        .top_free  (top_free),
        .pop       (pop),
        .pop_word  (pop_word)
    );

    fff_out_reg #(.WIDTH(WIDTH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pop),
        .load_word (pop_word),
        .rd_par    (rd_par),
        .ser_shift (ser_out_shift),
        .ser_en    (ser_out_en),
        .word      (out_word),
        .empty     (out_empty)
    );

    // Parallel pins: drive enable plus data forced quiet when disabled.
    assign dout_oe = oe;
    assign dout    = oe ? out_word : '0;
    assign ser_q   = out_word[0];

    assert_reset_flags_R1: assert property (@(posedge clk)
        !rst_n |=> (out_empty && !in_full));
    assert_pins_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (dout == '0 && !dout_oe));

endmodule

// File: tb/fallthru_fifo_bench.sv
module fallthru_fifo_bench;
    localparam int W = 4;
    localparam int D = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic par_load = 1'b0;
    logic [W-1:0] din = '0;
    logic ser_in = 1'b0, ser_in_shift = 1'b0, ser_in_en = 1'b0;
    logic xfer_n = 1'b1;
    logic in_full;
    logic rd_par = 1'b0, oe = 1'b0;
    logic [W-1:0] dout;
    logic dout_oe;
    logic ser_out_shift = 1'b0, ser_out_en = 1'b0;
    logic ser_q, out_empty;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fallthru_fifo #(.WIDTH(W), .DEPTH(D)) u_fallthru_fifo (
        .clk(clk), .rst_n(rst_n), .par_load(par_load), .din(din),
        .ser_in(ser_in), .ser_in_shift(ser_in_shift), .ser_in_en(ser_in_en),
        .xfer_n(xfer_n), .in_full(in_full), .rd_par(rd_par), .oe(oe),
        .dout(dout), .dout_oe(dout_oe), .ser_out_shift(ser_out_shift),
        .ser_out_en(ser_out_en), .ser_q(ser_q), .out_empty(out_empty)
    );

    // bit 4: 1 = serial entry, 0 = parallel; bits 3:0: the word
    localparam logic [4:0] VEC [8] = '{5'h0A, 5'h15, 5'h03, 5'h1C,
                                       5'h0F, 5'h10, 5'h16, 5'h09};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic load_par(input logic [W-1:0] d);
        par_load = 1'b1;
        din = d;
        tick();
        par_load = 1'b0;
    endtask

    task automatic load_ser(input logic [W-1:0] d);
        ser_in_en = 1'b1;
        for (int i = 0; i < W; i++) begin
            ser_in = d[i];
            ser_in_shift = 1'b1;
            tick();
        end
        ser_in_shift = 1'b0;
        ser_in_en = 1'b0;
    endtask

    task automatic push_word();
        xfer_n = 1'b0;
        for (int i = 0; i < 40 && in_full; i++) tick();
        xfer_n = 1'b1;
    endtask

    task automatic wait_out();
        for (int i = 0; i < 40 && out_empty; i++) tick();
    endtask

    task automatic read_par(output logic [W-1:0] v);
        oe = 1'b1;
        #1;
        v = dout;
        rd_par = 1'b1;
        tick();
        rd_par = 1'b0;
        oe = 1'b0;
    endtask

    task automatic read_ser(output logic [W-1:0] v);
        ser_out_en = 1'b1;
        for (int i = 0; i < W; i++) begin
            v[i] = ser_q;
            ser_out_shift = 1'b1;
            tick();
        end
        ser_out_shift = 1'b0;
        ser_out_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        int cnt;
        @(negedge clk);
        do_reset();
        // R1: reset flags
        chk(in_full == 1'b0, "R1 in_full", in_full, 0);
        chk(out_empty == 1'b1, "R1 out_empty", out_empty, 1);

        // Table walk: mixed entry, alternating exit modes (R2 R3 R4 R6 R8 R9)
        foreach (VEC[i]) begin
            if (VEC[i][4]) load_ser(VEC[i][3:0]);
            else           load_par(VEC[i][3:0]);
            chk(in_full == 1'b1, "R2/R3 full after entry", in_full, 1);
            push_word();
            chk(in_full == 1'b0, "R4 full clears on transfer", in_full, 0);
        end
        foreach (VEC[i]) begin
            wait_out();
            if (i % 2) read_ser(v);
            else       read_par(v);
            chk(v == VEC[i][3:0], "R6 order", v, VEC[i][3:0]);
        end
        chk(out_empty == 1'b1, "R9 empty after last serial", out_empty, 1);

        // R5: exact settle delay
        do_reset();
        load_par(4'h5);
        xfer_n = 1'b0;
        tick();
        xfer_n = 1'b1;
        cnt = 0;
        for (int i = 0; i < 40 && out_empty; i++) begin
            tick();
            cnt++;
        end
        chk(cnt == D, "R5 settle edges", cnt, D);

        // R8: pins quiet while oe low, word visible while high
        oe = 1'b0;
        #1;
        chk(dout == '0 && dout_oe == 1'b0, "R8 oe low", {dout_oe, dout}, 0);
        oe = 1'b1;
        #1;
        chk(dout == 4'h5 && dout_oe == 1'b1, "R8 oe high", {dout_oe, dout}, 5'h15);
        oe = 1'b0;

        // R9: gated serial shift is ignored
        ser_out_shift = 1'b1;
        ser_out_en = 1'b0;
        tick();
        tick();
        ser_out_shift = 1'b0;
        chk(out_empty == 1'b0, "R9 gated shift keeps word", out_empty, 0);
        ser_out_en = 1'b1;
        #1;
        chk(ser_q == 1'b1, "R9 bit0 first", ser_q, 1);
        ser_out_en = 1'b0;
        read_par(v);
        chk(v == 4'h5, "R9 word unchanged", v, 5);
        chk(out_empty == 1'b1, "R8 read empties", out_empty, 1);

        // R3: gated serial input ignored; partial serial word not full
        ser_in_en = 1'b0;
        ser_in_shift = 1'b1;
        ser_in = 1'b1;
        for (int i = 0; i < W; i++) tick();
        ser_in_shift = 1'b0;
        chk(in_full == 1'b0, "R3 gated shift ignored", in_full, 0);
        ser_in_en = 1'b1;
        for (int i = 0; i < W - 1; i++) begin
            ser_in_shift = 1'b1;
            tick();
        end
        ser_in_shift = 1'b0;
        ser_in_en = 1'b0;
        chk(in_full == 1'b0, "R3 not full before last bit", in_full, 0);
        do_reset();

        // R2 and R4: load while full ignored; xfer high holds
        load_par(4'hA);
        load_par(4'h3);
        tick();
        tick();
        chk(in_full == 1'b1, "R4 xfer high holds", in_full, 1);
        push_word();
        wait_out();
        read_par(v);
        chk(v == 4'hA, "R2 load while full ignored", v, 4'hA);

        // R7: capacity DEPTH+1, next word blocked
        do_reset();
        for (int i = 0; i < D + 1; i++) begin
            load_par(4'((i * 7 + 3) & 15));
            push_word();
        end
        load_par(4'((D + 1) * 7 + 3));
        xfer_n = 1'b0;
        for (int i = 0; i < 40; i++) tick();
        chk(in_full == 1'b1, "R7 blocked when full", in_full, 1);
        read_par(v);
        for (int i = 0; i < 40 && in_full; i++) tick();
        xfer_n = 1'b1;
        chk(in_full == 1'b0, "R7 enters after read", in_full, 0);
        chk(v == 4'h3, "R7 first word", v, 3);
        for (int i = 1; i < D + 2; i++) begin
            wait_out();
            read_par(v);
            chk(v == 4'((i * 7 + 3) & 15), "R7 order after fill", v, (i * 7 + 3) & 15);
        end

        // R10: reset mid-operation discards words
        for (int i = 0; i < 5; i++) begin
            load_par(4'(i));
            push_word();
        end
        do_reset();
        for (int i = 0; i < D + 4; i++) tick();
        chk(out_empty == 1'b1, "R10 nothing after reset", out_empty, 1);
        chk(in_full == 1'b0, "R10 input clear", in_full, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule